// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sits between a host register bus and the command side of a memory card interface. The host loads a 32-bit argument and then writes a command word that carries a 6-bit index and a set of control flags. A write with the enable flag set, and without the hold flag, starts a request to the card side. The request carries the index and the argument.

The card side acknowledges with a byte count (0, 4 or 16) or an error strobe. It then streams the reply one byte per cycle. The block checks that count against the shape of reply that the command asked for. A good reply is packed big-endian into four 32-bit response words. Each command ends by raising exactly one sticky status flag: response received, command sent, or timeout. Serial encoding, CRC and real timeouts live elsewhere.

Top module: `card_cmd_engine`

## Requirements
- R1: After reset all three flags, `busy` and `cardReq` are 0, and every readable register (addresses 0 to 5) reads 0.
- R2: The command word (bus address 1) holds the index in bits 5:0, response-expected in bit 6, long-reply in bit 7, an interrupt-mode bit in bit 8, a hold bit in bit 9 and enable in bit 10. A write with bit 10 = 1 and bit 9 = 0 raises `cardReq`, with `cardIndex` set to bits 5:0 and `cardArg` set to the argument register (address 0). Bit 8 has no effect on issuing.
- R3: The stored command reads back with bit 10 = 0. A command write with bit 10 = 0 is stored but raises no request.
- R4: A command write with bits 10 and 9 both 1 is stored but not issued. No request is raised and no flag is set.
- R5: `cardReq` stays high until a cycle with `cardAck`. `cardIndex` and `cardArg` do not change while `busy` is 1.
- R6: An acknowledge with `cardErr` = 1 sets the timeout flag, whether or not a response was expected.
- R7: With response-expected set, a timeout is raised in three cases: a count of 0, a count of 4 when long-reply is set, or any count other than 4 or 16. On a timeout the response words keep their previous values.
- R8: A 4-byte reply to a short request sets the response flag. Word 0 (address 2) receives the first byte in bits 31:24 through the fourth byte in bits 7:0. Words 1 to 3 become 0.
- R9: A 16-byte reply is accepted whether or not long-reply is set. Bytes 4k to 4k+3 fill word k, big-endian (addresses 2 to 5), and bit 0 of word 3 is forced to 0.
- R10: Without response-expected, and with no error, the command-sent flag is set once all announced bytes are consumed, or right after the acknowledge when the count is 0. The response words are left unchanged.
- R11: The flags are sticky. `flagClr` bit 0 clears timeout, bit 1 clears response received, and bit 2 clears command sent. Each clear bit affects only its own flag.
- R12: Argument and command writes that arrive while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for writes and reads (0 arg, 1 command, 2..5 response words) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at `regAddr` |
| flagClr | input | 3 | Per-flag clear strobes (bit0 timeout, bit1 response, bit2 sent) |
| flagTimeout | output | 1 | Sticky timeout flag |
| flagRespEnd | output | 1 | Sticky response-received flag |
| flagSent | output | 1 | Sticky command-sent flag |
| busy | output | 1 | A command is in flight |
| cardReq | output | 1 | Request to the card side |
| cardIndex | output | 6 | Command index sent with the request |
| cardArg | output | 32 | Argument sent with the request |
| cardAck | input | 1 | Card acknowledge, qualifies `cardLen` and `cardErr` |
| cardErr | input | 1 | Card reports an error with the acknowledge |
| cardLen | input | 5 | Number of reply bytes that will follow |
| cardByteValid | input | 1 | Reply byte strobe |
| cardByte | input | 8 | Reply byte |

## Verification
The difficult cases are the ones where the card's reply does not match the request. Examples are a 4-byte reply to a long request and an odd count such as 7. In both cases every byte must still be drained, and the previously captured response words must survive. The bench's card responder takes the count and the error strobe as free arguments, so it can produce these mismatches on demand. Before each mismatch the bench reads the response words back and compares them afterwards. Writes issued during a stretched acknowledge delay reach the ignored-while-busy window.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;
  localparam int IDX_W    = 6;
  localparam int RESP_BIT = 6;
  localparam int LONG_BIT = 7;
  localparam int IRQ_BIT  = 8;
  localparam int HOLD_BIT = 9;
  localparam int EN_BIT   = 10;
  localparam int CMD_W    = 11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_STREAM
  } cmdState_t;

  typedef struct packed {
    logic latchCmd;
    logic latchArg;
    logic shiftByte;
    logic commitShort;
    logic commitLong;
    logic setTimeout;
    logic setRespEnd;
    logic setSent;
  } cmdStrobe_t;
endpackage

// File: rtl/card_cmd_ctrl.sv
module card_cmd_ctrl
  import card_cmd_pkg::*;
#(
  parameter int LEN_W       = 5,
  parameter int SHORT_BYTES = 4,
  parameter int LONG_BYTES  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic             argWrite,
  input  logic             wrEnable,
  input  logic             wrHold,
  input  logic             wrRespExp,
  input  logic             wrLong,
  input  logic             cardAck,
  input  logic             cardErr,
  input  logic [LEN_W-1:0] cardLen,
  input  logic             cardByteValid,
  output cmdStrobe_t       strb,
  output logic             cardReq,
  output logic             busy
);
  localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(SHORT_BYTES);
  localparam logic [LEN_W-1:0] LONG_LEN  = LEN_W'(LONG_BYTES);
  localparam logic [LEN_W-1:0] ONE_LEFT  = LEN_W'(1);

  cmdState_t        state, nextState;
  logic             needResp, needLong;
  logic [LEN_W-1:0] lenReg, byteCnt;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        strb.latchArg = argWrite;
        strb.latchCmd = cmdWrite;
        if (cmdWrite && wrEnable && !wrHold) nextState = ST_REQ;
      end
      ST_REQ: begin
        if (cardAck) begin
          if (cardErr) begin
            strb.setTimeout = 1'b1;
            nextState       = ST_IDLE;
          end else if (cardLen == '0) begin
            strb.setTimeout = needResp;
            strb.setSent    = !needResp;
            nextState       = ST_IDLE;
          end else begin
            nextState = ST_STREAM;
          end
        end
      end
      ST_STREAM: begin
        if (cardByteValid) begin
          strb.shiftByte = 1'b1;
          if (byteCnt == ONE_LEFT) begin
            nextState = ST_IDLE;
            if (!needResp) begin
              strb.setSent = 1'b1;
            end else if (lenReg == LONG_LEN) begin
              strb.commitLong = 1'b1;
              strb.setRespEnd = 1'b1;
            end else if (lenReg == SHORT_LEN && !needLong) begin
              strb.commitShort = 1'b1;
              strb.setRespEnd  = 1'b1;
            end else begin
              strb.setTimeout = 1'b1;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      needResp <= 1'b0;
      needLong <= 1'b0;
      lenReg   <= '0;
      byteCnt  <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && cmdWrite) begin
        needResp <= wrRespExp;
        needLong <= wrLong;
      end
      if (state == ST_REQ && cardAck) begin
        lenReg  <= cardLen;
        byteCnt <= cardLen;
      end else if (state == ST_STREAM && cardByteValid) begin
        byteCnt <= byteCnt - ONE_LEFT;
      end
    end
  end

  assign cardReq = (state == ST_REQ);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/card_cmd_dpath.sv
module card_cmd_dpath
  import card_cmd_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int RESP_WORDS = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  cmdStrobe_t                          strb,
  input  logic [WORD_W-1:0]                   wrData,
  input  logic [7:0]                          byteIn,
  input  logic [2:0]                          flagClr,
  output logic [CMD_W-1:0]                    cmdReg,
  output logic [WORD_W-1:0]                   argReg,
  output logic [RESP_WORDS-1:0][WORD_W-1:0]   respOut,
  output logic                                flagTimeout,
  output logic                                flagRespEnd,
  output logic                                flagSent
);
  localparam int BUF_W = RESP_WORDS * WORD_W;

  logic [BUF_W-1:0] shiftBuf, bufNext;

  assign bufNext = {shiftBuf[BUF_W-9:0], byteIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      argReg   <= '0;
      shiftBuf <= '0;
    end else begin
      if (strb.latchCmd) begin
        cmdReg         <= wrData[CMD_W-1:0];
        cmdReg[EN_BIT] <= 1'b0;
      end
      if (strb.latchArg) argReg <= wrData;
      if (strb.shiftByte) shiftBuf <= bufNext;
    end
  end

  for (genvar k = 0; k < RESP_WORDS; k++) begin : g_resp
    localparam int HI = BUF_W - 1 - k * WORD_W;
    logic [WORD_W-1:0] longWord, shortWord;
    if (k == RESP_WORDS - 1) begin : g_last
      assign longWord = {bufNext[HI -: WORD_W-1], 1'b0};
    end else begin : g_mid
      assign longWord = bufNext[HI -: WORD_W];
    end
    if (k == 0) begin : g_first
      assign shortWord = bufNext[WORD_W-1:0];
    end else begin : g_zero
      assign shortWord = '0;
    end
    always_ff @(posedge clk) begin
      if (!rstN) respOut[k] <= '0;
      else if (strb.commitLong) respOut[k] <= longWord;
      else if (strb.commitShort) respOut[k] <= shortWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagTimeout <= 1'b0;
      flagRespEnd <= 1'b0;
      flagSent    <= 1'b0;
    end else begin
      flagTimeout <= strb.setTimeout | (flagTimeout & ~flagClr[0]);
      flagRespEnd <= strb.setRespEnd | (flagRespEnd & ~flagClr[1]);
      flagSent    <= strb.setSent    | (flagSent    & ~flagClr[2]);
    end
  end
endmodule

// File: rtl/card_cmd_engine.sv
module card_cmd_engine
  import card_cmd_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int RESP_WORDS  = 4,
  parameter int ADDR_W      = 3,
  parameter int LEN_W       = 5,
  parameter int SHORT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic [2:0]        flagClr,
  output logic              flagTimeout,
  output logic              flagRespEnd,
  output logic              flagSent,
  output logic              busy,
  output logic              cardReq,
  output logic [IDX_W-1:0]  cardIndex,
  output logic [WORD_W-1:0] cardArg,
  input  logic              cardAck,
  input  logic              cardErr,
  input  logic [LEN_W-1:0]  cardLen,
  input  logic              cardByteValid,
  input  logic [7:0]        cardByte
);
  localparam int LONG_BYTES = RESP_WORDS * WORD_W / 8;
  localparam logic [ADDR_W-1:0] ARG_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(1);
  localparam int RESP_BASE = 2;

  cmdStrobe_t                         strb;
  logic [CMD_W-1:0]                   cmdReg;
  logic [WORD_W-1:0]                  argReg;
  logic [RESP_WORDS-1:0][WORD_W-1:0]  respOut;

  card_cmd_ctrl #(
    .LEN_W(LEN_W), .SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(LONG_BYTES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWrite(regWrEn && regAddr == CMD_ADDR),
    .argWrite(regWrEn && regAddr == ARG_ADDR),
    .wrEnable(regWrData[EN_BIT]), .wrHold(regWrData[HOLD_BIT]),
    .wrRespExp(regWrData[RESP_BIT]), .wrLong(regWrData[LONG_BIT]),
    .cardAck(cardAck), .cardErr(cardErr), .cardLen(cardLen),
    .cardByteValid(cardByteValid),
    .strb(strb), .cardReq(cardReq), .busy(busy)
  );

  card_cmd_dpath #(.WORD_W(WORD_W), .RESP_WORDS(RESP_WORDS)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .byteIn(cardByte), .flagClr(flagClr),
    .cmdReg(cmdReg), .argReg(argReg), .respOut(respOut),
    .flagTimeout(flagTimeout), .flagRespEnd(flagRespEnd), .flagSent(flagSent)
  );

  always_comb begin
    regRdData = '0;
    if (regAddr == ARG_ADDR) regRdData = argReg;
    else if (regAddr == CMD_ADDR) regRdData = WORD_W'(cmdReg);
    for (int k = 0; k < RESP_WORDS; k++)
      if (int'(regAddr) == RESP_BASE + k) regRdData = respOut[k];
  end

  assign cardIndex = cmdReg[IDX_W-1:0];
  assign cardArg   = argReg;
endmodule

// File: rtl/card_cmd_chk.sv
module card_cmd_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  regAddr,
  input logic [31:0] regRdData,
  input logic [2:0]  flagClr,
  input logic        flagTimeout,
  input logic        flagRespEnd,
  input logic        flagSent,
  input logic        busy,
  input logic        cardReq,
  input logic [5:0]  cardIndex,
  input logic [31:0] cardArg,
  input logic        cardAck
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardReq && !cardAck |=> cardReq);

  // R5
  req_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cardArg) && $stable(cardIndex));

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({$rose(flagTimeout), $rose(flagRespEnd), $rose(flagSent)}) <= 1);

  // R11
  flag_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(flagTimeout) || $rose(flagRespEnd) || $rose(flagSent)) |-> $past(busy));

  // R11
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagTimeout && !flagClr[0] |=> flagTimeout);

  // R11
  resp_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagRespEnd && !flagClr[1] |=> flagRespEnd);

  // R9
  last_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 3'd5 |-> !regRdData[0]);

  // R3
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 3'd1 |-> !regRdData[10]);
endmodule

bind card_cmd_engine card_cmd_chk i_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .flagClr(flagClr), .flagTimeout(flagTimeout), .flagRespEnd(flagRespEnd),
  .flagSent(flagSent), .busy(busy), .cardReq(cardReq), .cardIndex(cardIndex),
  .cardArg(cardArg), .cardAck(cardAck)
);

// File: tb/test_card_cmd_engine.sv
module test_card_cmd_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [2:0]  flagClr = '0;
  logic        flagTimeout, flagRespEnd, flagSent, busy, cardReq;
  logic [5:0]  cardIndex;
  logic [31:0] cardArg;
  logic        cardAck = 1'b0;
  logic        cardErr = 1'b0;
  logic [4:0]  cardLen = '0;
  logic        cardByteValid = 1'b0;
  logic [7:0]  cardByte = '0;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  card_cmd_engine i_card_cmd_engine (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] mk(input int idx, input bit resp, input bit lng,
                                     input bit irq, input bit hold, input bit en);
    return {en, hold, irq, lng, resp, 6'(idx)};
  endfunction

  function automatic logic [7:0] bval(input logic [7:0] seed, input int i);
    return seed + 8'(i * 17);
  endfunction

  function automatic logic [31:0] word(input logic [7:0] seed, input int k);
    return {bval(seed, 4*k), bval(seed, 4*k+1), bval(seed, 4*k+2), bval(seed, 4*k+3)};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic card(input bit err, input int len, input int delay, input logic [7:0] seed);
    while (!cardReq) @(negedge clk);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      check("R5", "request held", 32'(cardReq), 32'd1);
    end
    cardAck = 1'b1; cardErr = err; cardLen = 5'(len);
    @(negedge clk);
    cardAck = 1'b0; cardErr = 1'b0;
    if (!err) begin
      for (int i = 0; i < len; i++) begin
        cardByteValid = 1'b1; cardByte = bval(seed, i);
        @(negedge clk);
      end
    end
    cardByteValid = 1'b0;
  endtask

  task automatic flags(input string req, input bit t, input bit r, input bit s);
    check(req, "flags {timeout,resp,sent}", {29'd0, flagTimeout, flagRespEnd, flagSent},
          {29'd0, t, r, s});
  endtask

  task automatic clearAll();
    @(negedge clk); flagClr = 3'b111;
    @(negedge clk); flagClr = 3'b000;
  endtask

  task automatic snapResp(output logic [31:0] w [4]);
    for (int k = 0; k < 4; k++) rd(3'(2 + k), w[k]);
  endtask

  task automatic cmpResp(input string req, input logic [31:0] w [4]);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(3'(2 + k), v);
      check(req, $sformatf("response word %0d kept", k), v, w[k]);
    end
  endtask

  task automatic test_reset();
    logic [31:0] v;
    flags("R1", 0, 0, 0);
    check("R1", "busy", 32'(busy), 0);
    check("R1", "cardReq", 32'(cardReq), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1", $sformatf("reg %0d", a), v, 0);
    end
  endtask

  task automatic test_short();
    logic [31:0] v;
    logic [10:0] c = mk(17, 1, 0, 0, 0, 1);
    wr(0, 32'hCAFE0001);
    wr(1, 32'(c));
    check("R2", "cardReq raised", 32'(cardReq), 1);
    check("R2", "cardIndex", 32'(cardIndex), 17);
    check("R2", "cardArg", cardArg, 32'hCAFE0001);
    card(0, 4, 0, 8'h10);
    flags("R8", 0, 1, 0);
    rd(2, v); check("R8", "word0", v, word(8'h10, 0));
    for (int k = 1; k < 4; k++) begin
      rd(3'(2 + k), v); check("R8", $sformatf("word%0d zero", k), v, 0);
    end
    rd(1, v); check("R3", "enable cleared in readback", v, 32'(c & ~11'h400));
    clearAll();
  endtask

  task automatic test_long(input bit lng, input logic [7:0] seed);
    logic [31:0] v;
    wr(1, 32'(mk(2, 1, lng, 0, 0, 1)));
    card(0, 16, 0, seed);
    flags("R9", 0, 1, 0);
    for (int k = 0; k < 4; k++) begin
      rd(3'(2 + k), v);
      check("R9", $sformatf("long word%0d", k), v,
            (k == 3) ? (word(seed, k) & ~32'd1) : word(seed, k));
    end
    clearAll();
  endtask

  task automatic test_bad(input bit lng, input int len, input string what);
    logic [31:0] w [4];
    snapResp(w);
    wr(1, 32'(mk(3, 1, lng, 0, 0, 1)));
    card(0, len, 0, 8'h77);
    check("R7", what, {29'd0, flagTimeout, flagRespEnd, flagSent}, 32'b100);
    check("R7", "idle after drain", 32'(busy), 0);
    cmpResp("R7", w);
    clearAll();
  endtask

  task automatic test_err();
    wr(1, 32'(mk(6, 0, 0, 0, 0, 1)));
    card(1, 0, 0, 8'h00);
    flags("R6", 1, 0, 0);
    clearAll();
  endtask

  task automatic test_noresp(input int len);
    logic [31:0] w [4];
    snapResp(w);
    wr(1, 32'(mk(4, 0, 0, 0, 0, 1)));
    card(0, len, 0, 8'h55);
    flags("R10", 0, 0, 1);
    cmpResp("R10", w);
    clearAll();
  endtask

  task automatic test_not_issued(input bit hold, input string req);
    logic [31:0] v;
    logic [10:0] c = mk(7, 1, 0, 0, hold, hold);
    wr(1, 32'(c));
    repeat (5) @(negedge clk);
    check(req, "no request", 32'(cardReq), 0);
    check(req, "not busy", 32'(busy), 0);
    flags(req, 0, 0, 0);
    rd(1, v); check(req, "stored command", v, 32'(c & ~11'h400));
  endtask

  task automatic test_irq();
    wr(1, 32'(mk(10, 1, 0, 1, 0, 1)));
    check("R2", "interrupt bit issues", 32'(cardReq), 1);
    card(0, 4, 0, 8'h31);
    flags("R2", 0, 1, 0);
    clearAll();
  endtask

  task automatic test_busy_write();
    logic [31:0] v;
    wr(0, 32'h1111_2222);
    wr(1, 32'(mk(11, 1, 0, 0, 0, 1)));
    wr(0, 32'h3333_4444);
    wr(1, 32'(mk(12, 1, 0, 0, 0, 1)));
    check("R12", "arg unchanged on pins", cardArg, 32'h1111_2222);
    check("R12", "index unchanged", 32'(cardIndex), 11);
    card(0, 4, 3, 8'h62);
    rd(0, v); check("R12", "arg readback", v, 32'h1111_2222);
    rd(1, v); check("R12", "cmd index readback", {26'd0, v[5:0]}, 11);
    check("R12", "no second request", 32'(cardReq), 0);
    clearAll();
  endtask

  task automatic test_sticky();
    wr(1, 32'(mk(13, 1, 0, 0, 0, 1)));
    card(0, 4, 0, 8'h05);
    repeat (10) @(negedge clk);
    flags("R11", 0, 1, 0);
    @(negedge clk); flagClr = 3'b101;
    @(negedge clk); flagClr = 3'b000;
    flags("R11", 0, 1, 0);
    @(negedge clk); flagClr = 3'b010;
    @(negedge clk); flagClr = 3'b000;
    flags("R11", 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_short();
    test_long(1, 8'h40);
    test_long(0, 8'h21);
    test_bad(1, 4, "long request, 4-byte reply");
    test_bad(0, 0, "zero-length reply");
    test_bad(0, 7, "odd-length reply");
    test_err();
    test_noresp(0);
    test_noresp(4);
    test_not_issued(1, "R4");
    test_not_issued(0, "R3");
    test_irq();
    test_busy_write();
    test_sticky();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule